// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block sits on the host side of a raw NAND flash channel and erases one block when asked. A one-cycle `start` pulse latches a block number and a mode bit. The block then drives the flash strobes and data bus through a fixed order of bus cycles:

- an erase-setup command (60h);
- two address bytes built from the block number;
- an erase-confirm command (D0h).

Every bus cycle is timed by parameterised low and high phase counts.

After confirm, the sequencer waits for the erase to finish. It can do this in one of two ways:

- **Ready-pin mode:** it watches the ready line, then reads the status register once.
- **Poll mode:** it issues the status command (70h) and repeats status read cycles until the ready bit reads 1.

A cycle counter that starts at confirm limits the wait. When the wait ends, the block sends command 00h so the device leaves status mode. It then pulses `done` with a pass/fail flag, a write-protect flag and a timeout flag. These flags hold their values until the next accepted start.

The controller is built as four parts:

- a state machine;
- a bus-cycle engine that produces the strobes;
- a combinational address formatter;
- a package holding the states and opcodes.

States and their transitions:

| State | Next state | Condition |
|---|---|---|
| `S_IDLE` | `S_CMD_SETUP` | start |
| `S_CMD_SETUP` | `S_ADDR_LO` | cycle ack |
| `S_ADDR_LO` | `S_ADDR_HI` | cycle ack |
| `S_ADDR_HI` | `S_CMD_CONFIRM` | cycle ack |
| `S_CMD_CONFIRM` | `S_GUARD` | cycle ack |
| `S_GUARD` | `S_WAIT_RDY` | guard count reached, ready-pin mode |
| `S_GUARD` | `S_CMD_STATUS` | guard count reached, poll mode |
| `S_WAIT_RDY` | `S_CMD_STATUS` | ready line high |
| `S_WAIT_RDY` | `S_CMD_EXIT` | timeout |
| `S_CMD_STATUS` | `S_READ_STATUS` | cycle ack |
| `S_READ_STATUS` | `S_CMD_EXIT` | final status read, or timeout |
| `S_READ_STATUS` | `S_READ_STATUS` | poll mode, busy read, no timeout |
| `S_CMD_EXIT` | `S_REPORT` | cycle ack |
| `S_REPORT` | `S_IDLE` | unconditional |

Top module: `nand_erase_seq`

## Requirements
- R1: The device sees its input bytes latched on rising edges of `nf_wstb_n`, in this order:
  1. command 60h;
  2. address byte low;
  3. address byte high;
  4. command D0h;
  5. in poll mode, or when the ready line rose in time, command 70h;
  6. command 00h last.

  Command bytes carry `nf_cmd_en`=1 and `nf_addr_en`=0; address bytes carry the reverse. The two enables are never high together.
- R2: With BLK_W=9 and LO_PAD=4, the address bytes are formed from the block number b as follows:
  - low byte = {b[3:0], 4'b1111};
  - high byte = {3'b111, b[8:4]}.
- R3: Each write cycle holds `nf_wstb_n` low for exactly T_LOW clocks, with `nf_doe`=1 and the byte stable through the rising edge. `nf_sel_n` is low whenever either strobe is low. `nf_wstb_n` and `nf_rstb_n` are never low together.
- R4: In ready-pin mode (`use_poll`=0), command 70h is sent only after `nf_ready` is seen high, following GUARD_CYC clocks after confirm. Exactly one status read cycle follows it.
- R5: In poll mode (`use_poll`=1), 70h is sent once after the guard. Status read cycles then repeat until status bit 6 reads 1.
- R6: From the final status read, `erase_fail` = bit 0 and `wr_protected` = NOT bit 7.
- R7: If readiness is not seen within TIMEOUT_CYC clocks of the confirm cycle ending, the block ends the run as follows:
  - `timed_out`=1 with `erase_fail` and `wr_protected` left 0;
  - it still sends 00h;
  - in ready-pin mode it sends no 70h.
- R8: Each run ends with command 00h before `done`.
- R9: `done` is high for exactly one clock, while `busy`=1. The three result flags stay unchanged from then until the next accepted start, which clears them.
- R10: A `start` pulse while `busy`=1 is ignored. The latched block number, the byte sequence and the count of `done` pulses are unchanged.
- R11: During reset and while idle, the outputs rest as follows:
  - all strobes and `nf_sel_n` high;
  - `nf_cmd_en` and `nf_addr_en` low;
  - `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Erase request pulse, taken only when idle |
| block_num | input | BLK_W | Block to erase, latched on accepted start |
| use_poll | input | 1 | 1 = status polling, 0 = wait on ready line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| erase_fail | output | 1 | Status bit 0 of final read |
| wr_protected | output | 1 | Inverted status bit 7 of final read |
| timed_out | output | 1 | Completion not seen within TIMEOUT_CYC |
| nf_sel_n | output | 1 | Device select, active low |
| nf_cmd_en | output | 1 | Command latch enable |
| nf_addr_en | output | 1 | Address latch enable |
| nf_wstb_n | output | 1 | Write strobe, data latched on rising edge |
| nf_rstb_n | output | 1 | Read strobe, active low |
| nf_dout | output | 8 | Byte driven to the device |
| nf_doe | output | 1 | Output enable for `nf_dout` |
| nf_din | input | 8 | Byte returned by the device |
| nf_ready | input | 1 | Device ready line, 1 = ready |

## Verification
The assertions check on every cycle:
- the exclusivity of the latch enables and of the two strobes;
- select framing around each strobe;
- data holding through the write-strobe rise;
- the single-cycle `done`;
- stability of the flags and of `busy` between starts.

Only the bench's scenarios can show:
- the byte order and address formatting for every block number;
- that the status command waits on the ready line;
- repeated polling;
- the decoding of the pass, fail and protect bits;
- both timeout paths;
- that a mid-run start is really ignored.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

    typedef enum logic [1:0] {
        XFER_CMD,
        XFER_ADDR,
        XFER_READ
    } xfer_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_SETUP,
        S_ADDR_LO,
        S_ADDR_HI,
        S_CMD_CONFIRM,
        S_GUARD,
        S_WAIT_RDY,
        S_CMD_STATUS,
        S_READ_STATUS,
        S_CMD_EXIT,
        S_REPORT
    } seq_t;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_STATUS      = 8'h70;
    localparam logic [7:0] OP_READ_MODE   = 8'h00;

    localparam int ST_FAIL_BIT  = 0;
    localparam int ST_READY_BIT = 6;
    localparam int ST_WPOK_BIT  = 7;

endpackage

// File: rtl/nand_blk_addr.sv
module nand_blk_addr #(
    parameter int BLK_W  = 9,
    parameter int LO_PAD = 4
) (
    input  logic [BLK_W-1:0] blk,
    output logic [7:0]       addr_lo,
    output logic [7:0]       addr_hi
);
    localparam int HI_PAD = 16 - BLK_W - LO_PAD;

    logic [15:0] packed_addr;

    // unused low and high positions are filled with ones
    assign packed_addr = {{HI_PAD{1'b1}}, blk, {LO_PAD{1'b1}}};
    assign addr_lo     = packed_addr[7:0];
    assign addr_hi     = packed_addr[15:8];
endmodule

// File: rtl/nand_strobe_phy.sv
module nand_strobe_phy
    import nand_erase_pkg::*;
#(
    parameter int T_LOW  = 3,
    parameter int T_HIGH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  xfer_t      kind,
    input  logic [7:0] wbyte,
    output logic       idle,
    output logic       ack,
    output logic [7:0] rbyte,
    output logic       cmd_en,
    output logic       addr_en,
    output logic       wstb_n,
    output logic       rstb_n,
    output logic [7:0] dout,
    output logic       doe,
    input  logic [7:0] din
);
    localparam int TMAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
    localparam int CW   = $clog2(TMAX + 1);

    phase_t         ph_q;
    logic [CW-1:0]  cnt_q;
    xfer_t          kind_q;
    logic [7:0]     byte_q;
    logic [7:0]     rbyte_q;
    logic           low_end;
    logic           high_end;
    logic           active;

    assign low_end  = (ph_q == PH_LOW)  && (cnt_q == CW'(T_LOW - 1));
    assign high_end = (ph_q == PH_HIGH) && (cnt_q == CW'(T_HIGH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            cnt_q   <= '0;
            kind_q  <= XFER_CMD;
            byte_q  <= '0;
            rbyte_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (go) begin
                    ph_q   <= PH_LOW;
                    cnt_q  <= '0;
                    kind_q <= kind;
                    byte_q <= wbyte;
                end
                PH_LOW: if (low_end) begin
                    ph_q  <= PH_HIGH;
                    cnt_q <= '0;
                    if (kind_q == XFER_READ) rbyte_q <= din;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                PH_HIGH: if (high_end) begin
                    ph_q <= PH_IDLE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        active  = (ph_q != PH_IDLE);
        idle    = !active;
        ack     = high_end;
        rbyte   = rbyte_q;
        cmd_en  = active && (kind_q == XFER_CMD);
        addr_en = active && (kind_q == XFER_ADDR);
        wstb_n  = !((ph_q == PH_LOW) && (kind_q != XFER_READ));
        rstb_n  = !((ph_q == PH_LOW) && (kind_q == XFER_READ));
        doe     = active && (kind_q != XFER_READ);
        dout    = byte_q;
    end
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nand_erase_pkg::*;
#(
    parameter int BLK_W       = 9,
    parameter int LO_PAD      = 4,
    parameter int T_LOW       = 3,
    parameter int T_HIGH      = 2,
    parameter int GUARD_CYC   = 4,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] block_num,
    input  logic             use_poll,
    output logic             busy,
    output logic             done,
    output logic             erase_fail,
    output logic             wr_protected,
    output logic             timed_out,
    output logic             nf_sel_n,
    output logic             nf_cmd_en,
    output logic             nf_addr_en,
    output logic             nf_wstb_n,
    output logic             nf_rstb_n,
    output logic [7:0]       nf_dout,
    output logic             nf_doe,
    input  logic [7:0]       nf_din,
    input  logic             nf_ready
);
    localparam int WAIT_W = $clog2(TIMEOUT_CYC + 1);

    seq_t              st_q, st_d;
    logic [BLK_W-1:0]  blk_q;
    logic              poll_q;
    logic [WAIT_W-1:0] wait_q;
    logic              fail_q, prot_q, tmo_q;
    logic [7:0]        adr_lo, adr_hi;
    logic              step, go, px_idle, px_ack;
    xfer_t             kind;
    logic [7:0]        wbyte, rbyte;
    logic              tmo, guard_end, stat_final, counting;

    nand_blk_addr #(.BLK_W(BLK_W), .LO_PAD(LO_PAD)) u_addr (
        .blk(blk_q), .addr_lo(adr_lo), .addr_hi(adr_hi)
    );

    nand_strobe_phy #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_phy (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .wbyte(wbyte),
        .idle(px_idle), .ack(px_ack), .rbyte(rbyte),
        .cmd_en(nf_cmd_en), .addr_en(nf_addr_en),
        .wstb_n(nf_wstb_n), .rstb_n(nf_rstb_n),
        .dout(nf_dout), .doe(nf_doe), .din(nf_din)
    );

    assign tmo        = (wait_q >= WAIT_W'(TIMEOUT_CYC - 1));
    assign guard_end  = (wait_q == WAIT_W'(GUARD_CYC - 1));
    assign stat_final = rbyte[ST_READY_BIT] || !poll_q;
    assign counting   = (st_q == S_GUARD) || (st_q == S_WAIT_RDY) ||
                        (st_q == S_CMD_STATUS) || (st_q == S_READ_STATUS);

    // which bus cycle each state requests
    always_comb begin
        step  = 1'b1;
        kind  = XFER_CMD;
        wbyte = OP_READ_MODE;
        unique case (st_q)
            S_CMD_SETUP:   wbyte = OP_ERASE_SETUP;
            S_ADDR_LO:     begin kind = XFER_ADDR; wbyte = adr_lo; end
            S_ADDR_HI:     begin kind = XFER_ADDR; wbyte = adr_hi; end
            S_CMD_CONFIRM: wbyte = OP_ERASE_GO;
            S_CMD_STATUS:  wbyte = OP_STATUS;
            S_READ_STATUS: kind = XFER_READ;
            S_CMD_EXIT:    wbyte = OP_READ_MODE;
            default:       step = 1'b0;
        endcase
        go = step && px_idle;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:        if (start)  st_d = S_CMD_SETUP;
            S_CMD_SETUP:   if (px_ack) st_d = S_ADDR_LO;
            S_ADDR_LO:     if (px_ack) st_d = S_ADDR_HI;
            S_ADDR_HI:     if (px_ack) st_d = S_CMD_CONFIRM;
            S_CMD_CONFIRM: if (px_ack) st_d = S_GUARD;
            S_GUARD:       if (guard_end) st_d = poll_q ? S_CMD_STATUS : S_WAIT_RDY;
            S_WAIT_RDY:    if (nf_ready) st_d = S_CMD_STATUS;
                           else if (tmo) st_d = S_CMD_EXIT;
            S_CMD_STATUS:  if (px_ack) st_d = S_READ_STATUS;
            S_READ_STATUS: if (px_ack && (stat_final || tmo)) st_d = S_CMD_EXIT;
            S_CMD_EXIT:    if (px_ack) st_d = S_REPORT;
            S_REPORT:      st_d = S_IDLE;
            default:       st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= '0;
            poll_q <= 1'b0;
            wait_q <= '0;
            fail_q <= 1'b0;
            prot_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            if (st_q == S_IDLE && start) begin
                blk_q  <= block_num;
                poll_q <= use_poll;
                fail_q <= 1'b0;
                prot_q <= 1'b0;
                tmo_q  <= 1'b0;
            end
            if (st_q == S_CMD_CONFIRM)   wait_q <= '0;
            else if (counting && !tmo)   wait_q <= wait_q + 1'b1;
            if (st_q == S_READ_STATUS && px_ack && stat_final) begin
                fail_q <= rbyte[ST_FAIL_BIT];
                prot_q <= !rbyte[ST_WPOK_BIT];
            end
            if ((st_q == S_WAIT_RDY && !nf_ready && tmo) ||
                (st_q == S_READ_STATUS && px_ack && !stat_final && tmo))
                tmo_q <= 1'b1;
        end
    end

    always_comb begin
        busy         = (st_q != S_IDLE);
        done         = (st_q == S_REPORT);
        nf_sel_n     = (st_q == S_IDLE) || (st_q == S_REPORT);
        erase_fail   = fail_q;
        wr_protected = prot_q;
        timed_out    = tmo_q;
    end
endmodule

// File: rtl/nand_erase_chk.sv
module nand_erase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       erase_fail,
    input logic       wr_protected,
    input logic       timed_out,
    input logic       nf_sel_n,
    input logic       nf_cmd_en,
    input logic       nf_addr_en,
    input logic       nf_wstb_n,
    input logic       nf_rstb_n,
    input logic [7:0] nf_dout,
    input logic       nf_doe
);
    assert_latch_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cmd_en && nf_addr_en));

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_wstb_n && !nf_rstb_n));

    assert_sel_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_wstb_n || !nf_rstb_n) |-> !nf_sel_n);

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_wstb_n) |-> (nf_doe && $stable(nf_dout)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_flags_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({erase_fail, wr_protected, timed_out}));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nf_wstb_n && nf_rstb_n && nf_sel_n && !nf_cmd_en && !nf_addr_en));
endmodule

bind nand_erase_seq nand_erase_chk u_chk (.*);

// File: tb/sim_nand_erase_seq.sv
module sim_nand_erase_seq;
    localparam int TL  = 2;
    localparam int TH  = 2;
    localparam int GD  = 3;
    localparam int TMO = 120;

    logic       clk = 1'b0;
    logic       rst_n, start, use_poll;
    logic [8:0] block_num;
    logic       busy, done, erase_fail, wr_protected, timed_out;
    logic       nf_sel_n, nf_cmd_en, nf_addr_en, nf_wstb_n, nf_rstb_n, nf_doe;
    logic [7:0] nf_dout, nf_din;
    logic       nf_ready;

    always #4 clk = ~clk;

    nand_erase_seq #(.BLK_W(9), .LO_PAD(4), .T_LOW(TL), .T_HIGH(TH),
                     .GUARD_CYC(GD), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .block_num(block_num),
        .use_poll(use_poll), .busy(busy), .done(done), .erase_fail(erase_fail),
        .wr_protected(wr_protected), .timed_out(timed_out), .nf_sel_n(nf_sel_n),
        .nf_cmd_en(nf_cmd_en), .nf_addr_en(nf_addr_en), .nf_wstb_n(nf_wstb_n),
        .nf_rstb_n(nf_rstb_n), .nf_dout(nf_dout), .nf_doe(nf_doe),
        .nf_din(nf_din), .nf_ready(nf_ready)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---- device model ----
    logic       log_en = 1'b0;
    logic [7:0] wlog [16];
    logic [1:0] wkind [16];
    int         wn = 0;
    int         rd_n = 0;
    int         cyc = 0;
    int         busy_until = 0;
    int         m_busy_len = 0;
    logic       m_fail = 1'b0, m_prot = 1'b0;
    logic       st_mode = 1'b0;
    logic       rdy_at_status = 1'b0;
    logic       doe_ok = 1'b1;
    int         dones = 0;
    int         lowc = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) nf_ready <= (cyc >= busy_until);
    always @(negedge clk) if (log_en && done) dones++;

    assign nf_din = (!nf_rstb_n && st_mode) ? {~m_prot, nf_ready, 5'b0, m_fail} : 8'h00;

    always @(posedge nf_wstb_n) if (log_en) begin
        if (wn < 16) begin
            wlog[wn]  = nf_dout;
            wkind[wn] = {nf_addr_en, nf_cmd_en};
        end
        wn++;
        if (!nf_doe) doe_ok = 1'b0;
        if (nf_cmd_en && nf_dout == 8'h70) begin st_mode = 1'b1; rdy_at_status = nf_ready; end
        if (nf_cmd_en && nf_dout == 8'h00) st_mode = 1'b0;
        if (nf_cmd_en && nf_dout == 8'hD0) busy_until = cyc + m_busy_len;
    end

    always @(negedge nf_rstb_n) if (log_en) rd_n++;

    // R3: write strobe low width
    always @(negedge clk) if (log_en) begin
        if (!nf_wstb_n) lowc++;
        else if (lowc != 0) begin
            check("R3 write strobe low width", lowc, TL);
            lowc = 0;
        end
    end

    task automatic run(input logic [8:0] b, input logic poll, input logic f, input logic p,
                       input int blen, input logic tmo_exp, input logic inject);
        logic [7:0] eb [6];
        logic [1:0] ek [6];
        int ne, t, d0;
        logic [2:0] flags;
        while (!nf_ready) @(negedge clk);
        m_fail = f; m_prot = p; m_busy_len = blen;
        wn = 0; rd_n = 0; doe_ok = 1'b1; rdy_at_status = 1'b0;
        d0 = dones;
        block_num = b; use_poll = poll; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", busy, 1);
        if (inject) begin
            repeat (8) @(negedge clk);
            block_num = ~b; use_poll = ~poll; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R10 busy unaffected by second start", busy, 1);
        end
        t = 0;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        if (t >= 3000) begin
            check("R9 done never seen", 0, 1);
            return;
        end
        check("R9 busy during done", busy, 1);
        check("R7 timeout flag", timed_out, tmo_exp);
        check("R6 fail flag", erase_fail, tmo_exp ? 1'b0 : f);
        check("R6 protect flag", wr_protected, tmo_exp ? 1'b0 : p);
        // expected bus bytes (R1, R2, R8): kinds 01 = command, 10 = address
        eb[0] = 8'h60;                ek[0] = 2'b01;
        eb[1] = {b[3:0], 4'hF};       ek[1] = 2'b10;
        eb[2] = {3'b111, b[8:4]};     ek[2] = 2'b10;
        eb[3] = 8'hD0;                ek[3] = 2'b01;
        ne = 4;
        if (poll || !tmo_exp) begin eb[ne] = 8'h70; ek[ne] = 2'b01; ne++; end
        eb[ne] = 8'h00; ek[ne] = 2'b01; ne++;
        check("R1 write cycle count", wn, ne);
        for (int i = 0; i < 6; i++) if (i < ne && i < wn) begin
            check((i == 1 || i == 2) ? "R2 address byte" : (i == ne - 1 ? "R8 exit command" : "R1 command byte"),
                  wlog[i], eb[i]);
            check("R1 latch enables", wkind[i], ek[i]);
        end
        check("R3 data enabled at strobe rise", doe_ok, 1);
        if (!poll && !tmo_exp) begin
            check("R4 status only after ready", rdy_at_status, 1);
            check("R4 single status read", rd_n, 1);
        end
        if (!poll && tmo_exp) check("R7 no status read on pin timeout", rd_n, 0);
        if (poll) check("R5 at least one status read", rd_n >= 1, 1);
        if (poll && blen >= 40) check("R5 repeated status reads", rd_n > 1, 1);
        flags = {timed_out, erase_fail, wr_protected};
        @(negedge clk);
        check("R9 done single cycle", done, 0);
        check("R9 idle after done", busy, 0);
        repeat (3) @(negedge clk);
        check("R9 flags held", {timed_out, erase_fail, wr_protected}, flags);
        check("R10 one done per run", dones - d0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; use_poll = 1'b0; block_num = '0; nf_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 reset busy", busy, 0);
        check("R11 reset done", done, 0);
        check("R11 reset strobes", {nf_wstb_n, nf_rstb_n, nf_sel_n}, 3'b111);
        check("R11 reset latch enables", {nf_cmd_en, nf_addr_en}, 2'b00);
        check("R11 reset flags", {erase_fail, wr_protected, timed_out}, 3'b000);
        rst_n = 1'b1;
        log_en = 1'b1;
        @(negedge clk);
        // sweep all block numbers, mode and status bits from block bits
        for (int b = 0; b < 512; b++)
            run(9'(b), b[0], b[1], b[2], 3 + (b % 6), 1'b0, 1'b0);
        // long erase in both modes (R4, R5)
        run(9'h1A5, 1'b1, 1'b0, 1'b0, 40, 1'b0, 1'b0);
        run(9'h05A, 1'b0, 1'b1, 1'b0, 40, 1'b0, 1'b0);
        // timeouts (R7)
        run(9'h0F0, 1'b0, 1'b1, 1'b1, 400, 1'b1, 1'b0);
        run(9'h10F, 1'b1, 1'b1, 1'b1, 400, 1'b1, 1'b0);
        // normal run after timeout clears flags (R9)
        run(9'h033, 1'b0, 1'b0, 1'b0, 5, 1'b0, 1'b0);
        // start while busy (R10)
        run(9'h005, 1'b0, 1'b0, 1'b1, 30, 1'b0, 1'b1);
        run(9'h1C8, 1'b1, 1'b1, 1'b0, 30, 1'b0, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule